// File: doc/BRIEF.md
# Fine-Grained Thread Selection Unit

This block sits in the select stage of a single-issue, six-stage pipeline (fetch, select, decode, execute, memory, writeback) that four hardware threads share. Every cycle it looks at each thread's status and hands the next decode slot to exactly one thread that can run. It registers the choice as a one-hot grant with a valid flag.

A thread can run only when it has an instruction waiting and nothing holds it back. A thread is held back by an unresolved cache miss, a pending trap, a multiply or divide still in progress, or a clash over a shared unit. If several threads can run, the one that was granted longest ago wins. Threads may keep issuing behind a load on the guess that the load hits. When a load-miss report arrives for a thread, the unit drops that thread from selection in that cycle and raises a squash for it one cycle later, so the younger instruction already in flight can be killed.

Top module: `thread_select_unit`

## Requirements
- R1: While `rst_n` is low and on the first sample after it rises, `grant_o` is 0, `grant_valid_o` is 0 and `squash_o` is 0. The recency order starts as 0,1,2,3, with thread 0 the least recently granted.
- R2: The grant is registered: the status inputs present before a rising clock edge decide the `grant_o` seen after that edge. `grant_o` has at most one bit set, with bit t standing for thread t. `grant_valid_o` is 1 exactly when one bit of `grant_o` is set.
- R3: Thread t can be granted only when `inst_avail_i[t]` is 1 and, for that thread, `miss_pend_i`, `trap_pend_i`, `long_busy_i`, `rsrc_conflict_i` and `load_miss_i` are all 0.
- R4: When several threads can be granted, the grant goes to the one that was granted least recently.
- R5: After a grant, the granted thread becomes the most recently granted. With all four threads able to run, grants from reset therefore come in the order 0,1,2,3,0.
- R6: In a cycle where no thread can be granted, `grant_valid_o` and `grant_o` are 0 and the recency order does not change.
- R7: A thread with `miss_pend_i` high is never granted, even when it is the least recently granted thread.
- R8: A thread with `trap_pend_i` high is never granted.
- R9: A thread with `long_busy_i` or `rsrc_conflict_i` high is never granted.
- R10: When `load_miss_i[t]` is 1 before an edge, thread t is not granted at that edge, and `squash_o[t]` is 1 for the one cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_avail_i | input | 4 | Per thread: an instruction is waiting to issue |
| miss_pend_i | input | 4 | Per thread: a cache miss has not yet resolved |
| trap_pend_i | input | 4 | Per thread: a trap is pending |
| long_busy_i | input | 4 | Per thread: a multiply or divide is in progress |
| rsrc_conflict_i | input | 4 | Per thread: a shared unit is busy for it |
| load_miss_i | input | 4 | Per thread: a speculatively passed load reports a miss this cycle |
| grant_o | output | 4 | One-hot registered grant |
| grant_valid_o | output | 1 | A thread was granted |
| squash_o | output | 4 | Per thread: kill the younger in-flight instruction |

## Verification
The assertions assume that every status input is a clean level that is stable around the clock edge. They also assume that a load-miss report lasts one cycle for each miss and can arrive in any cycle, including together with other blocking inputs. The bench changes inputs only on the falling edge. It draws each status bit from `$urandom` with a fixed seed, biased so that all four threads are often ready together and sometimes none are, and adds directed cases that block the least recently granted thread by each cause in turn.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

   // Per-thread blocking status, collected for one thread
   typedef struct packed {
      logic avail;
      logic miss;
      logic trap;
      logic longop;
      logic conflict;
      logic ld_miss;
   } thr_stat_t;

   function automatic logic stat_ready(thr_stat_t s);
      return s.avail & ~(s.miss | s.trap | s.longop | s.conflict | s.ld_miss);
   endfunction

endpackage

// File: rtl/tsu_ready.sv
module tsu_ready #(
   parameter int NUM_THREADS = 4
) (
   input  logic [NUM_THREADS-1:0] avail_i,
   input  logic [NUM_THREADS-1:0] miss_i,
   input  logic [NUM_THREADS-1:0] trap_i,
   input  logic [NUM_THREADS-1:0] longop_i,
   input  logic [NUM_THREADS-1:0] conflict_i,
   input  logic [NUM_THREADS-1:0] ld_miss_i,
   output logic [NUM_THREADS-1:0] ready_o
);
   import tsu_pkg::*;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      thr_stat_t st;
      always_comb begin
         st.avail    = avail_i[t];
         st.miss     = miss_i[t];
         st.trap     = trap_i[t];
         st.longop   = longop_i[t];
         st.conflict = conflict_i[t];
         st.ld_miss  = ld_miss_i[t];
         ready_o[t]  = stat_ready(st);
      end
   end

endmodule

// File: rtl/tsu_lru_order.sv
module tsu_lru_order #(
   parameter int NUM_THREADS = 4,
   localparam int IW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] ready_i,
   output logic                   found_o,
   output logic [IW-1:0]          pick_id_o
);
   // Position 0 holds the least recently granted thread
   logic [NUM_THREADS-1:0][IW-1:0] order_q, order_d;
   logic [IW-1:0]                  pick_pos;

   always_comb begin
      found_o   = 1'b0;
      pick_pos  = '0;
      pick_id_o = '0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (!found_o && ready_i[order_q[i]]) begin
            found_o   = 1'b1;
            pick_pos  = IW'(i);
            pick_id_o = order_q[i];
         end
      end
   end

   // Remove the picked entry, close the gap, append it as most recent
   for (genvar g = 0; g < NUM_THREADS - 1; g++) begin : g_shift
      assign order_d[g] = (found_o && (IW'(g) >= pick_pos)) ? order_q[g+1] : order_q[g];
   end
   assign order_d[NUM_THREADS-1] = found_o ? pick_id_o : order_q[NUM_THREADS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= IW'(i);
      end else begin
         order_q <= order_d;
      end
   end

   p_idle_keeps_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !found_o |=> $stable(order_q));

   p_grant_to_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |=> order_q[NUM_THREADS-1] == $past(pick_id_o));

endmodule

// File: rtl/thread_select_unit.sv
module thread_select_unit #(
   parameter int NUM_THREADS = 4,
   localparam int IW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] inst_avail_i,
   input  logic [NUM_THREADS-1:0] miss_pend_i,
   input  logic [NUM_THREADS-1:0] trap_pend_i,
   input  logic [NUM_THREADS-1:0] long_busy_i,
   input  logic [NUM_THREADS-1:0] rsrc_conflict_i,
   input  logic [NUM_THREADS-1:0] load_miss_i,
   output logic [NUM_THREADS-1:0] grant_o,
   output logic                   grant_valid_o,
   output logic [NUM_THREADS-1:0] squash_o
);

   if (NUM_THREADS < 2) begin : g_bad_cfg
      $error("thread_select_unit needs at least two threads");
   end

   logic [NUM_THREADS-1:0] ready;
   logic                   found;
   logic [IW-1:0]          pick_id;

   tsu_ready #(.NUM_THREADS(NUM_THREADS)) u_ready (
      .avail_i    (inst_avail_i),
      .miss_i     (miss_pend_i),
      .trap_i     (trap_pend_i),
      .longop_i   (long_busy_i),
      .conflict_i (rsrc_conflict_i),
      .ld_miss_i  (load_miss_i),
      .ready_o    (ready)
   );

   tsu_lru_order #(.NUM_THREADS(NUM_THREADS)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready_i   (ready),
      .found_o   (found),
      .pick_id_o (pick_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_o       <= '0;
         grant_valid_o <= 1'b0;
         squash_o      <= '0;
      end else begin
         grant_o       <= found ? (NUM_THREADS'(1) << pick_id) : '0;
         grant_valid_o <= found;
         squash_o      <= load_miss_i;
      end
   end

   p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   p_valid_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o == ($countones(grant_o) == 1));

   p_blocked_not_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> (grant_o & $past(~inst_avail_i | miss_pend_i | trap_pend_i |
                                         long_busy_i | rsrc_conflict_i)) == '0);

   p_squash_not_granted_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_o != '0) |-> (squash_o & grant_o) == '0);

endmodule

// File: tb/thread_select_unit_test.sv
module thread_select_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NT-1:0] avail = '0, miss = '0, trap = '0, lng = '0, conf = '0, ldm = '0;
   logic [NT-1:0] grant, squash;
   logic          gvalid;

   int n_chk = 0;
   int n_bad = 0;
   int m_ord [NT];

   always #(CLK_PERIOD/2) clk = ~clk;

   thread_select_unit #(.NUM_THREADS(NT)) uut (
      .clk(clk), .rst_n(rst_n),
      .inst_avail_i(avail), .miss_pend_i(miss), .trap_pend_i(trap),
      .long_busy_i(lng), .rsrc_conflict_i(conf), .load_miss_i(ldm),
      .grant_o(grant), .grant_valid_o(gvalid), .squash_o(squash)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [NT-1:0] exp_ready();
      return avail & ~miss & ~trap & ~lng & ~conf & ~ldm;
   endfunction

   // Drive one cycle of status, predict, check after the edge
   task automatic step(string tag, logic [NT-1:0] a, logic [NT-1:0] m, logic [NT-1:0] t,
                       logic [NT-1:0] l, logic [NT-1:0] c, logic [NT-1:0] d);
      logic [NT-1:0] rdy, eg;
      int pos;
      @(negedge clk);
      avail = a; miss = m; trap = t; lng = l; conf = c; ldm = d;
      rdy = exp_ready();
      pos = -1;
      for (int i = 0; i < NT; i++)
         if (pos < 0 && rdy[m_ord[i]]) pos = i;
      eg = '0;
      if (pos >= 0) begin
         int id;
         id = m_ord[pos];
         eg[id] = 1'b1;
         for (int i = pos; i < NT - 1; i++) m_ord[i] = m_ord[i+1];
         m_ord[NT-1] = id;
      end
      @(posedge clk);
      #1;
      chk({tag, " grant"}, 32'(grant), 32'(eg));
      chk({tag, " valid"}, 32'(gvalid), 32'(pos >= 0));
      chk({tag, " squash"}, 32'(squash), 32'(d));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NT; i++) m_ord[i] = i;
      #(CLK_PERIOD * 3);
      @(negedge clk);
      chk("R1 grant in reset", 32'(grant), 0);
      chk("R1 valid in reset", 32'(gvalid), 0);
      rst_n = 1'b1;
      #1;
      chk("R1 squash after reset", 32'(squash), 0);

      // R5 / R4: all ready, round robin 0,1,2,3,0
      for (int k = 0; k < 5; k++) step("R5 rr", 4'hF, 0, 0, 0, 0, 0);
      // R6: nothing ready, order kept
      step("R6 idle", 4'h0, 0, 0, 0, 0, 0);
      step("R6 idle blocked", 4'hF, 4'h3, 4'hC, 0, 0, 0);
      step("R6 after idle", 4'hF, 0, 0, 0, 0, 0);
      // R4: subset ready picks the oldest among them
      step("R4 subset", 4'hA, 0, 0, 0, 0, 0);
      step("R4 subset2", 4'h6, 0, 0, 0, 0, 0);
      // R7..R9: block the oldest thread by each cause
      step("R7 miss", 4'hF, 4'(1 << m_ord[0]), 0, 0, 0, 0);
      step("R8 trap", 4'hF, 0, 4'(1 << m_ord[0]), 0, 0, 0);
      step("R9 long", 4'hF, 0, 0, 4'(1 << m_ord[0]), 0, 0);
      step("R9 conflict", 4'hF, 0, 0, 0, 4'(1 << m_ord[0]), 0);
      step("R3 no inst", 4'(~(1 << m_ord[0])), 0, 0, 0, 0, 0);
      // R10: load miss on the oldest thread
      step("R10 load miss", 4'hF, 0, 0, 0, 0, 4'(1 << m_ord[0]));
      step("R10 squash clears", 4'hF, 0, 0, 0, 0, 0);
      step("R10 only thread", 4'h4, 0, 0, 0, 0, 4'h4);

      // R3 random mix
      for (int k = 0; k < 600; k++) begin
         logic [NT-1:0] a, m, t, l, c, d;
         a = 4'($urandom) | 4'($urandom);
         m = 4'($urandom) & 4'($urandom) & 4'($urandom);
         t = 4'($urandom) & 4'($urandom) & 4'($urandom) & 4'($urandom);
         l = 4'($urandom) & 4'($urandom) & 4'($urandom);
         c = 4'($urandom) & 4'($urandom) & 4'($urandom);
         d = 4'($urandom) & 4'($urandom) & 4'($urandom) & 4'($urandom);
         step("R3 random", a, m, t, l, c, d);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule